// File: doc/BRIEF.md
# Instruction Prefix Latch and Remapper

This block sits between opcode fetch and instruction decode in an 8-bit accumulator-style processor. It watches each fetched opcode for one of four single-byte prefix codes: one that turns a direct addressing mode into its indirect counterpart, two that exchange the role of the accumulator with one index register, and one that redirects Y-specific operations onto the stack pointer. A recognised prefix sets a pending flag. Compatible prefixes may follow one another and their flags accumulate. The flags apply to the next instruction that is not a prefix and are dropped when that instruction reports completion.

While flags are pending, the block rewrites what the decoder produced for the target instruction. It swaps the source, destination and index register selects, moves Y onto S for Y-specific operations, and converts the addressing-mode code. A prefix that asks for a change the target does not support leaves that target untouched, so the prefix costs one cycle and does nothing else. Interrupts are held off from the moment a prefix is fetched until its target completes. The processor asserts the completion strobe only for non-prefix instructions.

Top module: `pfx_latch_remap`

## Requirements
- R1: Reset clears all four prefix flags. With no flag pending, the register selects and the addressing mode pass through unchanged.
- R2: `is_prefix_o` is high in any cycle where `op_valid_i` is high and `opcode_i` equals one of the prefix codes: indirect 0x9B, A/X exchange 0xFB, A/Y exchange 0xEB, Y-as-stack 0x8B. The matching flag reads high from the following cycle.
- R3: Pending flags survive any number of cycles and any non-prefix opcode. A cycle with `instr_done_i` high clears them for the next cycle.
- R4: The A/X and A/Y exchange flags are never high together, and Y-as-stack is never high with A/Y. A newly fetched prefix clears any pending flag it conflicts with. Indirect combines with every other flag, and Y-as-stack combines with A/X.
- R5: When `instr_done_i` and a prefix fetch fall in the same cycle, the old flags are dropped and only the new prefix is pending afterwards.
- R6: `irq_inhibit_o` is high while any flag is pending and during the cycle a prefix opcode is presented. `irq_take_o` equals `irq_i` gated by the inverse of `irq_inhibit_o`.
- R7: Under indirect, addressing codes map as follows. zp 2 becomes (zp) 8, zp,X 3 becomes (zp,X) 9, zp,Y 4 becomes (zp),Y 10, abs 5 becomes (abs) 11, abs,X 6 becomes (abs,X) 12, and abs,Y 7 becomes (abs),Y 13.
- R8: Indirect leaves the mode unchanged when `has_zpi_i` is high, meaning the instruction already has both direct and indirect zero-page forms. It also leaves unchanged any mode outside codes 2 to 7.
- R9: Register codes are A=0, X=1, Y=2, S=3. Under A/X exchange, codes 0 and 1 swap on source, destination and index selects. Under A/Y exchange, codes 0 and 2 swap on all three.
- R10: Under Y-as-stack with `y_op_i` high, a source or destination select of Y (2) becomes S (3). The index select never becomes S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An opcode is being fetched this cycle |
| opcode_i | input | 8 | Fetched opcode byte |
| instr_done_i | input | 1 | The current non-prefix instruction completes |
| irq_i | input | 1 | Interrupt request |
| base_src_i | input | 2 | Decoder's source register select |
| base_dst_i | input | 2 | Decoder's destination register select |
| base_idx_i | input | 2 | Decoder's index register select |
| base_amode_i | input | 4 | Decoder's addressing-mode code |
| y_op_i | input | 1 | Instruction is a Y-specific operation |
| has_zpi_i | input | 1 | Instruction already has a zero-page indirect form |
| is_prefix_o | output | 1 | Current opcode is a prefix |
| pf_ind_o | output | 1 | Indirect flag pending |
| pf_oax_o | output | 1 | A/X exchange flag pending |
| pf_oay_o | output | 1 | A/Y exchange flag pending |
| pf_osy_o | output | 1 | Y-as-stack flag pending |
| src_sel_o | output | 2 | Remapped source select |
| dst_sel_o | output | 2 | Remapped destination select |
| idx_sel_o | output | 2 | Remapped index select |
| amode_o | output | 4 | Converted addressing mode |
| irq_inhibit_o | output | 1 | Interrupts blocked |
| irq_take_o | output | 1 | Interrupt may be accepted |

## Verification
Two functions can coincide in one cycle: the completion strobe that retires the current target and the fetch of a new prefix byte. Both edit the flag register. The bench provokes this with directed cases, for example a pending indirect flag met by an A/X exchange fetch with `instr_done_i` high. It also lets random stimulus raise the strobe and present prefix codes together often. The result is judged by the flags visible in the next cycle, which must hold only the new prefix. The interrupt gate must stay closed during the overlapping cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   // register select codes
   localparam logic [1:0] RS_A = 2'd0;
   localparam logic [1:0] RS_X = 2'd1;
   localparam logic [1:0] RS_Y = 2'd2;
   localparam logic [1:0] RS_S = 2'd3;

   // addressing mode codes
   localparam logic [3:0] AM_ZP    = 4'd2;
   localparam logic [3:0] AM_ZPX   = 4'd3;
   localparam logic [3:0] AM_ZPY   = 4'd4;
   localparam logic [3:0] AM_ABS   = 4'd5;
   localparam logic [3:0] AM_ABSX  = 4'd6;
   localparam logic [3:0] AM_ABSY  = 4'd7;
   localparam logic [3:0] AM_ZPI   = 4'd8;
   localparam logic [3:0] AM_ZPXI  = 4'd9;
   localparam logic [3:0] AM_ZPIY  = 4'd10;
   localparam logic [3:0] AM_ABSI  = 4'd11;
   localparam logic [3:0] AM_ABSXI = 4'd12;
   localparam logic [3:0] AM_ABSIY = 4'd13;

   localparam int RS_W = 2;
   localparam int AM_W = 4;

   typedef struct packed {
      logic ind;
      logic oax;
      logic oay;
      logic osy;
   } pfx_flags_t;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
   import pfx_pkg::*;
#(
   parameter int               OPC_W = 8,
   parameter logic [OPC_W-1:0] P_IND = 'h9B,
   parameter logic [OPC_W-1:0] P_OAX = 'hFB,
   parameter logic [OPC_W-1:0] P_OAY = 'hEB,
   parameter logic [OPC_W-1:0] P_OSY = 'h8B
) (
   input  logic             op_valid_i,
   input  logic [OPC_W-1:0] opcode_i,
   output pfx_flags_t       hit_o,
   output logic             is_prefix_o
);
   localparam int NPFX = 4;
   // ordered to match the flag struct, most significant first
   localparam logic [NPFX*OPC_W-1:0] CODE_VEC = {P_IND, P_OAX, P_OAY, P_OSY};

   logic [NPFX-1:0] hit_v;

   for (genvar k = 0; k < NPFX; k++) begin : g_cmp
      assign hit_v[k] = op_valid_i && (opcode_i == CODE_VEC[k*OPC_W +: OPC_W]);
   end

   assign hit_o       = pfx_flags_t'(hit_v);
   assign is_prefix_o = |hit_v;
endmodule

// File: rtl/pfx_state.sv
module pfx_state
   import pfx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pfx_flags_t hit_i,
   input  logic       done_i,
   output pfx_flags_t cur_o
);
   pfx_flags_t cur_q, nxt;

   always_comb begin
      // retire first, then merge the newly fetched prefix
      nxt = done_i ? '0 : cur_q;
      if (hit_i.ind) nxt.ind = 1'b1;
      if (hit_i.oax) begin
         nxt.oax = 1'b1;
         nxt.oay = 1'b0;
      end
      if (hit_i.oay) begin
         nxt.oay = 1'b1;
         nxt.oax = 1'b0;
         nxt.osy = 1'b0;
      end
      if (hit_i.osy) begin
         nxt.osy = 1'b1;
         nxt.oay = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
   end

   assign cur_o = cur_q;
endmodule

// File: rtl/pfx_regmap.sv
module pfx_regmap
   import pfx_pkg::*;
(
   input  pfx_flags_t       flags_i,
   input  logic             y_op_i,
   input  logic [RS_W-1:0]  src_i,
   input  logic [RS_W-1:0]  dst_i,
   input  logic [RS_W-1:0]  idx_i,
   output logic [RS_W-1:0]  src_o,
   output logic [RS_W-1:0]  dst_o,
   output logic [RS_W-1:0]  idx_o
);
   localparam int NSEL = 3;   // 0 src, 1 dst, 2 idx

   function automatic logic [RS_W-1:0] xchg(input logic [RS_W-1:0] c,
                                            input logic [RS_W-1:0] other);
      if (c == RS_A)       return other;
      else if (c == other) return RS_A;
      else                 return c;
   endfunction

   logic [RS_W-1:0] in_a  [NSEL];
   logic [RS_W-1:0] out_a [NSEL];

   assign in_a[0] = src_i;
   assign in_a[1] = dst_i;
   assign in_a[2] = idx_i;

   for (genvar g = 0; g < NSEL; g++) begin : g_sel
      // the stack pointer never takes over index duty
      localparam bit STACK_OK = (g != 2);
      logic [RS_W-1:0] stk;
      always_comb begin
         stk = in_a[g];
         if (STACK_OK && flags_i.osy && y_op_i && stk == RS_Y) stk = RS_S;
         if (flags_i.oax)      out_a[g] = xchg(stk, RS_X);
         else if (flags_i.oay) out_a[g] = xchg(stk, RS_Y);
         else                  out_a[g] = stk;
      end
   end

   assign src_o = out_a[0];
   assign dst_o = out_a[1];
   assign idx_o = out_a[2];
endmodule

// File: rtl/pfx_amode.sv
module pfx_amode
   import pfx_pkg::*;
(
   input  logic            ind_i,
   input  logic            has_zpi_i,
   input  logic [AM_W-1:0] mode_i,
   output logic [AM_W-1:0] mode_o
);
   always_comb begin
      mode_o = mode_i;
      if (ind_i && !has_zpi_i) begin
         case (mode_i)
            AM_ZP:   mode_o = AM_ZPI;
            AM_ZPX:  mode_o = AM_ZPXI;
            AM_ZPY:  mode_o = AM_ZPIY;
            AM_ABS:  mode_o = AM_ABSI;
            AM_ABSX: mode_o = AM_ABSXI;
            AM_ABSY: mode_o = AM_ABSIY;
            default: mode_o = mode_i;
         endcase
      end
   end
endmodule

// File: rtl/pfx_latch_remap.sv
module pfx_latch_remap
   import pfx_pkg::*;
#(
   parameter int               OPC_W         = 8,
   parameter logic [OPC_W-1:0] P_IND         = 'h9B,
   parameter logic [OPC_W-1:0] P_OAX         = 'hFB,
   parameter logic [OPC_W-1:0] P_OAY         = 'hEB,
   parameter logic [OPC_W-1:0] P_OSY         = 'h8B,
   parameter bit               EARLY_INHIBIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid_i,
   input  logic [OPC_W-1:0] opcode_i,
   input  logic             instr_done_i,
   input  logic             irq_i,
   input  logic [1:0]       base_src_i,
   input  logic [1:0]       base_dst_i,
   input  logic [1:0]       base_idx_i,
   input  logic [3:0]       base_amode_i,
   input  logic             y_op_i,
   input  logic             has_zpi_i,
   output logic             is_prefix_o,
   output logic             pf_ind_o,
   output logic             pf_oax_o,
   output logic             pf_oay_o,
   output logic             pf_osy_o,
   output logic [1:0]       src_sel_o,
   output logic [1:0]       dst_sel_o,
   output logic [1:0]       idx_sel_o,
   output logic [3:0]       amode_o,
   output logic             irq_inhibit_o,
   output logic             irq_take_o
);
   if (OPC_W < 2) begin : g_bad_width
      $error("opcode width too small");
   end
   if (P_IND == P_OAX || P_IND == P_OAY || P_IND == P_OSY ||
       P_OAX == P_OAY || P_OAX == P_OSY || P_OAY == P_OSY) begin : g_bad_codes
      $error("prefix codes must be distinct");
   end

   pfx_flags_t hit, cur;
   logic       fetch_pfx;

   pfx_decode #(
      .OPC_W(OPC_W), .P_IND(P_IND), .P_OAX(P_OAX), .P_OAY(P_OAY), .P_OSY(P_OSY)
   ) dec_i (
      .op_valid_i (op_valid_i),
      .opcode_i   (opcode_i),
      .hit_o      (hit),
      .is_prefix_o(fetch_pfx)
   );

   pfx_state st_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (hit),
      .done_i(instr_done_i),
      .cur_o (cur)
   );

   pfx_regmap rm_i (
      .flags_i(cur),
      .y_op_i (y_op_i),
      .src_i  (base_src_i),
      .dst_i  (base_dst_i),
      .idx_i  (base_idx_i),
      .src_o  (src_sel_o),
      .dst_o  (dst_sel_o),
      .idx_o  (idx_sel_o)
   );

   pfx_amode am_i (
      .ind_i    (cur.ind),
      .has_zpi_i(has_zpi_i),
      .mode_i   (base_amode_i),
      .mode_o   (amode_o)
   );

   logic pending;
   assign pending = |cur;

   if (EARLY_INHIBIT) begin : g_early
      assign irq_inhibit_o = pending || fetch_pfx;
   end else begin : g_late
      assign irq_inhibit_o = pending;
   end

   assign irq_take_o  = irq_i && !irq_inhibit_o;
   assign is_prefix_o = fetch_pfx;
   assign pf_ind_o    = cur.ind;
   assign pf_oax_o    = cur.oax;
   assign pf_oay_o    = cur.oay;
   assign pf_osy_o    = cur.osy;
endmodule

// File: rtl/pfx_latch_remap_chk.sv
module pfx_latch_remap_chk #(
   parameter int               OPC_W = 8,
   parameter logic [OPC_W-1:0] P_IND = 'h9B,
   parameter logic [OPC_W-1:0] P_OAX = 'hFB
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid_i,
   input logic [OPC_W-1:0] opcode_i,
   input logic             instr_done_i,
   input logic             is_prefix_o,
   input logic             pf_ind_o,
   input logic             pf_oax_o,
   input logic             pf_oay_o,
   input logic             pf_osy_o,
   input logic             irq_take_o,
   input logic [1:0]       base_src_i,
   input logic [3:0]       base_amode_i,
   input logic             y_op_i,
   input logic             has_zpi_i,
   input logic [1:0]       src_sel_o,
   input logic [3:0]       amode_o
);
   assert_xchg_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pf_oax_o && pf_oay_o));

   assert_osy_oay_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pf_osy_o && pf_oay_o));

   assert_ind_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid_i && opcode_i == P_IND |=> pf_ind_o);

   assert_oax_replaces_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid_i && opcode_i == P_OAX |=> pf_oax_o && !pf_oay_o);

   assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done_i && !is_prefix_o |=> !(pf_ind_o || pf_oax_o || pf_oay_o || pf_osy_o));

   assert_no_irq_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_ind_o || pf_oax_o || pf_oay_o || pf_osy_o) |-> !irq_take_o);

   assert_zp_indirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pf_ind_o && !has_zpi_i && base_amode_i == 4'd2 |-> amode_o == 4'd8);

   assert_zpi_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      has_zpi_i |-> amode_o == base_amode_i);

   assert_y_to_s_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pf_osy_o && y_op_i && base_src_i == 2'd2 |-> src_sel_o == 2'd3);
endmodule

bind pfx_latch_remap pfx_latch_remap_chk #(
   .OPC_W(OPC_W), .P_IND(P_IND), .P_OAX(P_OAX)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid_i  (op_valid_i),
   .opcode_i    (opcode_i),
   .instr_done_i(instr_done_i),
   .is_prefix_o (is_prefix_o),
   .pf_ind_o    (pf_ind_o),
   .pf_oax_o    (pf_oax_o),
   .pf_oay_o    (pf_oay_o),
   .pf_osy_o    (pf_osy_o),
   .irq_take_o  (irq_take_o),
   .base_src_i  (base_src_i),
   .base_amode_i(base_amode_i),
   .y_op_i      (y_op_i),
   .has_zpi_i   (has_zpi_i),
   .src_sel_o   (src_sel_o),
   .amode_o     (amode_o)
);

// File: tb/pfx_latch_remap_tb_top.sv
module pfx_latch_remap_tb_top;
   localparam logic [7:0] C_IND = 8'h9B;
   localparam logic [7:0] C_OAX = 8'hFB;
   localparam logic [7:0] C_OAY = 8'hEB;
   localparam logic [7:0] C_OSY = 8'h8B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [7:0] opcode = 8'h00;
   logic       done = 1'b0;
   logic       irq = 1'b0;
   logic [1:0] bsrc = 2'd0, bdst = 2'd0, bidx = 2'd0;
   logic [3:0] bam = 4'd0;
   logic       yop = 1'b0, zpi = 1'b0;

   logic       is_pfx, f_ind, f_oax, f_oay, f_osy, inh, take;
   logic [1:0] src_o, dst_o, idx_o;
   logic [3:0] am_o;

   int checks = 0;
   int errors = 0;
   logic [3:0] mflags = 4'b0000;   // {ind, oax, oay, osy}

   always #10 clk = ~clk;   // 50 MHz

   pfx_latch_remap dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .opcode_i(opcode),
      .instr_done_i(done), .irq_i(irq), .base_src_i(bsrc), .base_dst_i(bdst),
      .base_idx_i(bidx), .base_amode_i(bam), .y_op_i(yop), .has_zpi_i(zpi),
      .is_prefix_o(is_pfx), .pf_ind_o(f_ind), .pf_oax_o(f_oax), .pf_oay_o(f_oay),
      .pf_osy_o(f_osy), .src_sel_o(src_o), .dst_sel_o(dst_o), .idx_sel_o(idx_o),
      .amode_o(am_o), .irq_inhibit_o(inh), .irq_take_o(take)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic match(input logic v, input logic [7:0] c);
      return v && (c == C_IND || c == C_OAX || c == C_OAY || c == C_OSY);
   endfunction

   function automatic logic [3:0] next_flags(input logic [3:0] f, input logic v,
                                             input logic [7:0] c, input logic d);
      logic [3:0] b;
      b = d ? 4'b0000 : f;
      if (v) begin
         if (c == C_IND) b[3] = 1'b1;
         if (c == C_OAX) begin b[2] = 1'b1; b[1] = 1'b0; end
         if (c == C_OAY) begin b[1] = 1'b1; b[2] = 1'b0; b[0] = 1'b0; end
         if (c == C_OSY) begin b[0] = 1'b1; b[1] = 1'b0; end
      end
      return b;
   endfunction

   function automatic logic [1:0] exp_sel(input logic [1:0] c, input logic [3:0] f,
                                          input logic y, input logic stk_ok);
      logic [1:0] r;
      r = c;
      if (stk_ok && f[0] && y && r == 2'd2) r = 2'd3;
      if (f[2]) r = (r == 2'd0) ? 2'd1 : (r == 2'd1) ? 2'd0 : r;
      else if (f[1]) r = (r == 2'd0) ? 2'd2 : (r == 2'd2) ? 2'd0 : r;
      return r;
   endfunction

   function automatic logic [3:0] exp_am(input logic [3:0] m, input logic [3:0] f,
                                         input logic z);
      if (!f[3] || z || m < 4'd2 || m > 4'd7) return m;
      return m + 4'd6;   // 2..7 map onto 8..13 in the same order
   endfunction

   // drive one cycle's inputs (at a falling edge), then check every output
   task automatic apply(input logic v, input logic [7:0] c, input logic d,
                        input logic i, input logic [1:0] s, input logic [1:0] t,
                        input logic [1:0] x, input logic [3:0] m, input logic y,
                        input logic z);
      logic ep;
      op_valid = v; opcode = c; done = d; irq = i;
      bsrc = s; bdst = t; bidx = x; bam = m; yop = y; zpi = z;
      #1;
      ep = match(v, c);
      check("R2 is_prefix", is_pfx, ep);
      check("R3 flags", {f_ind, f_oax, f_oay, f_osy}, mflags);
      check("R9 src", src_o, exp_sel(s, mflags, y, 1'b1));
      check("R9 dst", dst_o, exp_sel(t, mflags, y, 1'b1));
      check("R9 idx", idx_o, exp_sel(x, mflags, y, 1'b0));
      check("R7 amode", am_o, exp_am(m, mflags, z));
      check("R6 inhibit", inh, (|mflags) || ep);
      check("R6 take", take, i && !((|mflags) || ep));
   endtask

   task automatic advance();
      @(posedge clk);
      mflags = next_flags(mflags, op_valid, opcode, done);
      @(negedge clk);
   endtask

   task automatic pfx(input logic [7:0] c, input logic d);
      apply(1'b1, c, d, 1'b0, 2'd0, 2'd0, 2'd1, 4'd0, 1'b0, 1'b0);
      advance();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: flags clear and pass-through during reset
      #1;
      check("R1 flags in reset", {f_ind, f_oax, f_oay, f_osy}, 0);
      check("R1 amode passthrough", am_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      apply(1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 4'd5, 1'b1, 1'b0);
      check("R1 src passthrough", src_o, 2);
      check("R1 amode passthrough", am_o, 5);
      advance();

      // R7: indirect then zp target
      pfx(C_IND, 1'b0);
      apply(1'b1, 8'hA5, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 4'd2, 1'b0, 1'b0);
      check("R7 zp->(zp)", am_o, 8);
      check("R6 irq held while pending", take, 0);
      advance();
      apply(1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 4'd2, 1'b0, 1'b0);
      check("R3 cleared after done", {f_ind, f_oax, f_oay, f_osy}, 0);
      check("R6 irq allowed after target", take, 1);
      advance();

      // R8: existing indirect form, and non-convertible mode
      pfx(C_IND, 1'b0);
      apply(1'b1, 8'h12, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 4'd2, 1'b0, 1'b1);
      check("R8 zpi-capable unchanged", am_o, 2);
      advance();
      apply(1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 4'd1, 1'b0, 1'b0);
      check("R8 immediate unchanged", am_o, 1);
      advance();

      // R6: irq during the prefix fetch cycle
      apply(1'b1, C_OAX, 1'b0, 1'b1, 2'd0, 2'd0, 2'd1, 4'd0, 1'b0, 1'b0);
      check("R6 irq held on prefix fetch", take, 0);
      advance();
      // R9: A/X exchange
      apply(1'b1, 8'h65, 1'b1, 1'b0, 2'd0, 2'd0, 2'd1, 4'd3, 1'b0, 1'b0);
      check("R9 oax src", src_o, 1);
      check("R9 oax idx", idx_o, 0);
      advance();

      // R4: conflicts, newest wins; compatible ones accumulate
      pfx(C_OAX, 1'b0);
      pfx(C_OAY, 1'b0);
      check("R4 oay replaces oax", {f_ind, f_oax, f_oay, f_osy}, 4'b0010);
      pfx(C_OSY, 1'b0);
      check("R4 osy replaces oay", {f_ind, f_oax, f_oay, f_osy}, 4'b0001);
      pfx(C_OAX, 1'b0);
      pfx(C_IND, 1'b0);
      check("R4 ind+oax+osy accumulate", {f_ind, f_oax, f_oay, f_osy}, 4'b1101);
      // R10: Y becomes S for Y-specific op, index stays Y
      apply(1'b1, 8'hA0, 1'b0, 1'b0, 2'd2, 2'd2, 2'd2, 4'd6, 1'b1, 1'b0);
      check("R10 y->s src", src_o, 3);
      check("R10 idx not stack", idx_o, 2);
      check("R7 abs,x->(abs,x)", am_o, 12);
      advance();

      // R5: completion and new prefix in the same cycle
      pfx(C_OAX, 1'b1);
      check("R5 only new prefix", {f_ind, f_oax, f_oay, f_osy}, 4'b0100);
      apply(1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0, 1'b0, 1'b0);
      advance();

      // random mix: every cycle compared against the bench model
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [7:0] c;
         r = $urandom % 8;
         case (r)
            0: c = C_IND;
            1: c = C_OAX;
            2: c = C_OAY;
            3: c = C_OSY;
            default: c = 8'($urandom);
         endcase
         apply(($urandom % 4) != 0, c, ($urandom % 3) == 0, 1'($urandom),
               2'($urandom), 2'($urandom), 2'($urandom), 4'($urandom),
               1'($urandom), ($urandom % 4) == 0);
         advance();
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule